// File: doc/BRIEF.md
# NAND Completion Status Poller

This block waits for a NAND device to finish a program or erase operation. A one-cycle `start` pulse makes it drive a status-query command onto a byte-wide command-latch/strobe bus, release the command latch for one cycle, and then read the device's status byte again and again. Reads are spaced by a fixed number of microsecond ticks. Polling stops when the device reports ready or when a millisecond budget, captured at start, runs out.

The block reports one of three outcomes: success, timeout, or a failure reported by the device. The outcome code stays stable until the next operation finishes. It is qualified by a one-cycle `done` pulse, and the last status byte read is also visible on an output. The timebase is an external one-cycle strobe at 1 MHz. Spacing and budget are counted in steps of `TICKS_PER_STEP` strobes. With the defaults a step is 10 µs and a millisecond is 100 steps.

Top module: `nand_status_poller`

## Requirements
- R1: After reset `done` is 0, `busy` is 0, `result` is 2'b00, `status_last` is 8'h00, chip enable, write strobe and read strobe are high (inactive), and the command latch is low.
- R2: Starting from idle, a `start` pulse produces this bus sequence on consecutive cycles: (a) one cycle with chip enable low, command latch high, write strobe low and `nand_dout` equal to `STATUS_CMD` (8'h70); (b) one cycle with only chip enable low; (c) the first status read, with the read strobe low for one cycle.
- R3: Consecutive status reads are separated by exactly `TICKS_PER_STEP` (10) tick strobes. The same spacing applies between the last read and a timeout result.
- R4: With a captured budget of T milliseconds and a device that never becomes ready, exactly 100·T+1 reads are made before the result is given; T = 0 gives exactly one read.
- R5: When a read shows status bit 6 (ready) set and status bit 0 (fail) clear, polling stops after that read and `result` is 2'b00 (OK).
- R6: When a read shows both ready (bit 6) and fail (bit 0) set, polling stops and `result` is 2'b10 (I/O error).
- R7: If the budget runs out while the last read lacks bit 6, `result` is 2'b01 (timeout), even if bit 0 of that byte is set. At `done`, `status_last` holds the last byte read.
- R8: `done` is high for exactly one cycle per operation, and `result` changes only in a cycle where `done` is high.
- R9: A `start` pulse while `busy` is high has no effect: no second command cycle is issued, and the read count and result are those of the original operation.
- R10: Chip enable stays low from the command cycle until the final read has been evaluated. It is high in the `done` cycle and whenever the block is idle.
- R11: `timeout_ms` is sampled only when an accepted `start` arrives; later changes do not alter the budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin polling |
| tick_us | input | 1 | One-cycle timebase strobe, 1 MHz |
| timeout_ms | input | TMO_W | Budget in milliseconds, captured at start |
| nand_din | input | 8 | Status byte from the device |
| nand_dout | output | 8 | Command byte to the device |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable, active high |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 OK, 01 timeout, 10 I/O error |
| status_last | output | 8 | Most recent status byte read |

## Verification
A corrupted interval counter shows up at the very next read. The number of strobes between read-strobe pulses then differs from ten, and that gap is measured on every gap of every run. A wrong step count or captured budget shows up only at completion, as a read count that differs from 100·T+1 at one of the sweep boundaries: exactly at the budget edge, or one read past it. A wrong decode of the status byte shows up in the `done` cycle as a wrong result code, or as polling that continues past a ready byte.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CMD  = 3'd1,
        ST_REL  = 3'd2,
        ST_RD   = 3'd3,
        ST_EVAL = 3'd4,
        ST_WAIT = 3'd5
    } poll_state_t;

    typedef enum logic [1:0] {
        RES_OK    = 2'b00,
        RES_TMO   = 2'b01,
        RES_IOERR = 2'b10
    } poll_res_t;

    typedef struct packed {
        poll_state_t       st;
        logic              done;
        poll_res_t         res;
        logic [BYTE_W-1:0] stat;
    } poll_ctl_t;

endpackage

// File: rtl/nsp_interval.sv
module nsp_interval #(
    parameter int unsigned TICKS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic step
);
    localparam int unsigned CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ivl_t;

    ivl_t ivl_d, ivl_q;

    always_comb begin
        ivl_d = ivl_q;
        step  = 1'b0;
        if (clear) begin
            ivl_d.cnt = '0;
        end else if (run && tick) begin
            if (ivl_q.cnt == LAST) begin
                ivl_d.cnt = '0;
                step      = 1'b1;
            end else begin
                ivl_d.cnt = ivl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ivl_q <= '0;
        else        ivl_q <= ivl_d;
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_q.cnt <= LAST);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(ivl_q.cnt));

endmodule

// File: rtl/nsp_budget.sv
module nsp_budget #(
    parameter int unsigned TMO_W        = 16,
    parameter int unsigned STEPS_PER_MS = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMO_W-1:0] tmo_ms,
    input  logic             inc,
    output logic             exhausted
);
    localparam int unsigned LIM_W  = TMO_W + $clog2(STEPS_PER_MS + 1);
    localparam int unsigned STEP_W = LIM_W + 1;

    typedef struct packed {
        logic [LIM_W-1:0]  limit;
        logic [STEP_W-1:0] steps;
    } bud_t;

    bud_t bud_d, bud_q;

    always_comb begin
        bud_d = bud_q;
        if (load) begin
            bud_d.limit = LIM_W'(tmo_ms) * LIM_W'(STEPS_PER_MS);
            bud_d.steps = '0;
        end else if (inc) begin
            bud_d.steps = bud_q.steps + 1'b1;
        end
    end

    // one more step would push the elapsed total past the budget
    assign exhausted = ({1'b0, bud_q.limit} <= bud_q.steps);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bud_q <= '0;
        else        bud_q <= bud_d;
    end

    // R4
    steps_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bud_q.steps <= ({1'b0, bud_q.limit} + STEP_W'(1)));

    // R11
    limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bud_q.limit));

endmodule

// File: rtl/nsp_status_eval.sv
module nsp_status_eval #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned RDY_BIT  = 6,
    parameter int unsigned FAIL_BIT = 0
) (
    input  logic [BYTE_W-1:0] status,
    output logic              ready,
    output logic              failed
);
    always_comb begin
        ready  = status[RDY_BIT];
        failed = status[RDY_BIT] & status[FAIL_BIT];
    end
endmodule

// File: rtl/nand_status_poller.sv
module nand_status_poller #(
    parameter int unsigned TMO_W          = 16,
    parameter int unsigned TICKS_PER_STEP = 10,
    parameter int unsigned STEPS_PER_MS   = 100,
    parameter logic [7:0]  STATUS_CMD     = 8'h70,
    parameter int unsigned RDY_BIT        = 6,
    parameter int unsigned FAIL_BIT       = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick_us,
    input  logic [TMO_W-1:0] timeout_ms,
    input  logic [7:0]       nand_din,
    output logic [7:0]       nand_dout,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic             busy,
    output logic             done,
    output logic [1:0]       result,
    output logic [7:0]       status_last
);
    import nsp_pkg::*;

    poll_ctl_t ctl_d, ctl_q;

    logic ivl_clear, ivl_run, ivl_step;
    logic bud_load, bud_exhausted;
    logic st_ready, st_failed;

    nsp_interval #(.TICKS(TICKS_PER_STEP)) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ivl_clear),
        .run   (ivl_run),
        .tick  (tick_us),
        .step  (ivl_step)
    );

    nsp_budget #(.TMO_W(TMO_W), .STEPS_PER_MS(STEPS_PER_MS)) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (bud_load),
        .tmo_ms    (timeout_ms),
        .inc       (ivl_step),
        .exhausted (bud_exhausted)
    );

    nsp_status_eval #(.BYTE_W(BYTE_W), .RDY_BIT(RDY_BIT), .FAIL_BIT(FAIL_BIT)) u_eval (
        .status (ctl_q.stat),
        .ready  (st_ready),
        .failed (st_failed)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ivl_clear  = 1'b0;
        ivl_run    = 1'b0;
        bud_load   = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st  = ST_CMD;
                    ivl_clear = 1'b1;
                    bud_load  = 1'b1;
                end
            end
            ST_CMD:  ctl_d.st = ST_REL;
            ST_REL:  ctl_d.st = ST_RD;
            ST_RD: begin
                ctl_d.stat = nand_din;
                ctl_d.st   = ST_EVAL;
            end
            ST_EVAL: begin
                ivl_run = 1'b1;
                if (st_ready) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.res  = st_failed ? RES_IOERR : RES_OK;
                end else begin
                    ctl_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                ivl_run = 1'b1;
                if (ivl_step) begin
                    if (bud_exhausted) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                        ctl_d.res  = RES_TMO;
                    end else begin
                        ctl_d.st = ST_RD;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_IDLE, done: 1'b0, res: RES_OK, stat: '0};
        else        ctl_q <= ctl_d;
    end

    assign busy        = (ctl_q.st != ST_IDLE);
    assign nand_ce_n   = (ctl_q.st == ST_IDLE);
    assign nand_cle    = (ctl_q.st == ST_CMD);
    assign nand_we_n   = (ctl_q.st != ST_CMD);
    assign nand_re_n   = (ctl_q.st != ST_RD);
    assign nand_dout   = (ctl_q.st == ST_CMD) ? STATUS_CMD : 8'h00;
    assign done        = ctl_q.done;
    assign result      = ctl_q.res;
    assign status_last = ctl_q.stat;

    // R2
    cmd_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |=> (!nand_ce_n && !nand_cle && nand_we_n && nand_re_n));

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R10
    ce_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !nand_ce_n);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !nand_cle) |=> nand_we_n);

endmodule

// File: tb/sim_nand_status_poller.sv
module sim_nand_status_poller;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        tick_us;
    logic [15:0] timeout_ms;
    logic [7:0]  nand_din;
    logic [7:0]  nand_dout;
    logic        nand_ce_n, nand_cle, nand_we_n, nand_re_n;
    logic        busy, done;
    logic [1:0]  result;
    logic [7:0]  status_last;

    int compared   = 0;
    int mismatched = 0;
    int reads      = 0;
    int ready_at   = 1;
    bit fail_bit   = 1'b0;

    always #2 clk = ~clk;

    // device model: the k-th read returns ready once k reaches ready_at
    assign nand_din = (reads >= ready_at) ? (8'h60 | {7'b0, fail_bit}) : 8'h81;

    nand_status_poller u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .tick_us (tick_us),
        .timeout_ms (timeout_ms), .nand_din (nand_din), .nand_dout (nand_dout),
        .nand_ce_n (nand_ce_n), .nand_cle (nand_cle), .nand_we_n (nand_we_n),
        .nand_re_n (nand_re_n), .busy (busy), .done (done), .result (result),
        .status_last (status_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        tick_us = 1'b0;
        forever begin
            repeat (3) @(negedge clk);
            tick_us <= 1'b1;
            @(negedge clk);
            tick_us <= 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    task automatic run_case(input int tmo, input int rdy, input bit fl, input bit disturb);
        int  exp_reads, exp_res, exp_stat, ticks, extra_we, cyc;
        bit  prev_win, got, dist_done;
        logic [1:0] held;
        @(negedge clk);
        timeout_ms = 16'(tmo);
        ready_at   = rdy;
        fail_bit   = fl;
        reads      = 0;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2 command cycle
        check(!nand_ce_n && nand_cle && !nand_we_n && nand_re_n && nand_dout == 8'h70,
              "R2 cmd", {nand_ce_n, nand_cle, nand_we_n, nand_re_n}, 4'b0101);
        ticks = 0; extra_we = 0; cyc = 0; prev_win = 0; got = 0; dist_done = 0;
        while (!got && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (tick_us && prev_win) ticks++;
            if (!nand_we_n) extra_we++;
            if (cyc == 1)
                check(!nand_ce_n && !nand_cle && nand_we_n && nand_re_n,
                      "R2 release", {nand_ce_n, nand_cle, nand_we_n, nand_re_n}, 4'b0011);
            if (cyc == 2)
                check(!nand_re_n, "R2 first read", nand_re_n, 0);
            if (done) begin
                got = 1;
            end else begin
                if (nand_ce_n) check(0, "R10 ce during poll", nand_ce_n, 0);
                if (!nand_re_n) begin
                    if (reads > 0 && ticks != 10) check(0, "R3 spacing", ticks, 10);
                    ticks = 0;
                    reads++;
                end
                if (disturb && reads == 3 && !dist_done) begin
                    start      = 1'b1;
                    timeout_ms = 16'd0;
                    dist_done  = 1;
                end
            end
            prev_win = busy && nand_re_n && (reads > 0);
        end
        check(got, "R8 done seen", got, 1);
        if (rdy <= 100 * tmo + 1) begin
            exp_reads = rdy;
            exp_res   = fl ? 2 : 0;
            exp_stat  = 8'h60 | fl;
        end else begin
            exp_reads = 100 * tmo + 1;
            exp_res   = 1;
            exp_stat  = 8'h81;
            check(ticks == 10, "R3 final gap", ticks, 10);
        end
        check(reads == exp_reads, disturb ? "R9 reads" : "R4 reads", reads, exp_reads);
        check(result == 2'(exp_res), exp_res == 1 ? "R7 result" : (fl ? "R6 result" : "R5 result"),
              result, exp_res);
        check(status_last == 8'(exp_stat), "R7 status_last", status_last, exp_stat);
        check(nand_ce_n && !busy, "R10 ce at done", nand_ce_n, 1);
        check(extra_we == 0, disturb ? "R9 no second cmd" : "R2 single cmd", extra_we, 0);
        held = result;
        @(negedge clk);
        check(!done, "R8 done width", done, 0);
        repeat (5) @(negedge clk);
        check(result == held && !done && nand_ce_n, "R8 result hold", result, held);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; timeout_ms = 16'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!done && !busy && result == 2'b00 && status_last == 8'h00,
              "R1 outputs", {done, busy, result}, 0);
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle,
              "R1 bus idle", {nand_ce_n, nand_we_n, nand_re_n, nand_cle}, 4'b1110);
        for (int t = 0; t < 3; t++) begin
            for (int f = 0; f < 2; f++) begin
                run_case(t, 1, f[0], 1'b0);
                run_case(t, 100 * t + 1, f[0], 1'b0);
                run_case(t, 100 * t + 2, f[0], 1'b0);
            end
        end
        run_case(0, 3, 1'b0, 1'b0);
        // R9 and R11: restart attempt plus budget change mid-poll
        run_case(1, 1000, 1'b1, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule